// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of devices onto a small number of shared bus interrupt lines. Each device has four interrupt pins. A requester reports one pin level change at a time over a valid/ready channel. The block keeps the last level of every device pin, so a report that repeats the stored level does nothing. When a level really changes, the block adds +1 or −1 to a per-line counter of asserted sources. A bus line is high exactly while its counter is non-zero, which makes it the OR of every pin mapped onto it. Each update touches only one counter, so no wide OR tree over all pins is needed.

The pin-to-line mapping rotates with the device number: a pin lands on line (device + pin) mod NUM_LINES. When `HAS_BRIDGE` is set, all devices sit behind a single forwarding stage. Their pins are first rotated onto the four secondary lines, (device + pin) mod 4. That secondary line is then rotated again, as a pin of the bridge slot `BRIDGE_SLOT`, giving line (BRIDGE_SLOT + secondary) mod NUM_LINES.

Control is a two-state machine:
- `ST_WAIT`: `req_ready` is high. An accepted request is captured and the machine moves to `ST_APPLY` (transition *accept*). Without a request it stays in `ST_WAIT` (transition *idle*).
- `ST_APPLY`: `req_ready` is low. The captured level is compared with the stored level and, if it differs, the pin store and the counter of the mapped line are updated. The machine always returns to `ST_WAIT` (transition *retire*).

Top module: `irq_line_aggregator`

## Requirements
- R1: After reset all bus lines are low, every stored pin level is 0 and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for exactly the one following cycle and is then high again.
- R3: A captured level of 1 on a pin whose stored level is 0 increments the counter of its mapped line by one and drives that line high. A level of 0 on a stored 1 decrements it. Between two clock edges at most one line output changes.
- R4: A request whose level equals the stored level of that pin changes nothing. A pin raised twice and then lowered once leaves its line low, and the sum of all counters always equals the number of stored pins at 1.
- R5: A line stays high while any pin mapped onto it is at 1, and goes low only when the last of them drops.
- R6: Without a bridge, pin p (0..3, the 2-bit `req_pin` value) of device d (the `req_dev` value) drives line (d + p) mod NUM_LINES.
- R7: Lowering a pin that is already low leaves every line unchanged, including a line held high by another source.
- R8: No counter ever exceeds 4·NUM_DEV or wraps below zero, even with every pin of every device high.
- R9: Line outputs hold their value during the `ST_APPLY` cycle and change only on the edge that ends it, one cycle after acceptance.
- R10: With `HAS_BRIDGE` set, pin p of device d drives line (BRIDGE_SLOT + ((d + p) mod 4)) mod NUM_LINES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A pin level report is offered |
| req_ready | output | 1 | Block can take a report this cycle |
| req_dev | input | DEV_W | Device number of the report |
| req_pin | input | 2 | Interrupt pin of that device, 0..3 |
| req_level | input | 1 | New level of that pin |
| line_out | output | NUM_LINES | Shared bus interrupt line levels |

## Verification
The hardest situation to reach is a counter near its limits, where many sources share a line and several redundant reports arrive. A wrong increment would only show once the line should have fallen. The stimulus raises all pins of all devices so that every counter reaches its maximum, then lowers them one by one. Redundant raises and lowers of already-set or already-clear pins are mixed in along the way. A reference model of the mapping is checked after each report on both the direct and the bridged instance.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int PINS_PER_DEV = 4;

    typedef enum logic [0:0] {
        ST_WAIT  = 1'b0,
        ST_APPLY = 1'b1
    } agg_state_e;

    // rotating swizzle of a pin onto a set of lines
    function automatic int rotate_line(input int dev, input int pin, input int lines);
        return (dev + pin) % lines;
    endfunction

endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV     = 8,
    parameter int NUM_LINES   = 4,
    parameter bit HAS_BRIDGE  = 1'b0,
    parameter int BRIDGE_SLOT = 1,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [DEV_W-1:0]  dev,
    input  logic [1:0]        pin,
    output logic [LINE_W-1:0] line
);

    generate
        if (HAS_BRIDGE) begin : g_bridged
            always_comb begin
                int secondary;
                secondary = rotate_line(int'(dev), int'(pin), PINS_PER_DEV);
                line = LINE_W'(rotate_line(BRIDGE_SLOT, secondary, NUM_LINES));
            end
        end else begin : g_direct
            always_comb begin
                line = LINE_W'(rotate_line(int'(dev), int'(pin), NUM_LINES));
            end
        end
    endgenerate

endmodule

// File: rtl/irq_pin_store.sv
module irq_pin_store
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int SRC_N = NUM_DEV * PINS_PER_DEV,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int IDX_W = DEV_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             wr_level,
    output logic             rd_level,
    output logic [SRC_N-1:0] levels
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            levels <= '0;
        end else if (wr_en) begin
            levels[idx] <= wr_level;
        end
    end

    assign rd_level = levels[idx];

endmodule

// File: rtl/irq_line_counters.sv
module irq_line_counters
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV   = 8,
    parameter int NUM_LINES = 4,
    localparam int SRC_N  = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W  = $clog2(SRC_N + 1),
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_en,
    input  logic                       step_up,
    input  logic [LINE_W-1:0]          step_line,
    output logic [NUM_LINES*CNT_W-1:0] cnt_flat,
    output logic [NUM_LINES-1:0]       line_out
);

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            logic [CNT_W-1:0] cnt;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (step_en && step_line == LINE_W'(l)) begin
                    cnt <= step_up ? cnt + 1'b1 : cnt - 1'b1;
                end
            end
            assign cnt_flat[l*CNT_W +: CNT_W] = cnt;
            assign line_out[l] = |cnt;
        end
    endgenerate

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV     = 8,
    parameter int NUM_LINES   = 4,
    parameter bit HAS_BRIDGE  = 1'b0,
    parameter int BRIDGE_SLOT = 1,
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int SRC_N  = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W  = $clog2(SRC_N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [DEV_W-1:0]     req_dev,
    input  logic [1:0]           req_pin,
    input  logic                 req_level,
    output logic [NUM_LINES-1:0] line_out
);

    agg_state_e state, state_nx;

    logic [DEV_W-1:0]           cap_dev;
    logic [1:0]                 cap_pin;
    logic                       cap_level;
    logic [LINE_W-1:0]          cap_line;
    logic                       stored_level;
    logic                       dev_ok;
    logic                       apply_step;
    logic [SRC_N-1:0]           pin_levels;
    logic [NUM_LINES*CNT_W-1:0] line_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_dev   <= '0;
            cap_pin   <= '0;
            cap_level <= 1'b0;
        end else if (state == ST_WAIT && req_valid) begin
            cap_dev   <= req_dev;
            cap_pin   <= req_pin;
            cap_level <= req_level;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (req_valid) state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_WAIT;
            default:  state_nx = ST_WAIT;
        endcase
    end

    assign dev_ok = int'(cap_dev) < NUM_DEV;

    // outputs of the state machine
    always_comb begin
        req_ready  = 1'b0;
        apply_step = 1'b0;
        unique case (state)
            ST_WAIT:  req_ready  = 1'b1;
            ST_APPLY: apply_step = dev_ok && (cap_level != stored_level);
            default:  req_ready  = 1'b0;
        endcase
    end

    irq_line_map #(
        .NUM_DEV     (NUM_DEV),
        .NUM_LINES   (NUM_LINES),
        .HAS_BRIDGE  (HAS_BRIDGE),
        .BRIDGE_SLOT (BRIDGE_SLOT)
    ) u_map (
        .dev  (cap_dev),
        .pin  (cap_pin),
        .line (cap_line)
    );

    irq_pin_store #(
        .NUM_DEV (NUM_DEV)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      ({cap_dev, cap_pin}),
        .wr_en    (apply_step),
        .wr_level (cap_level),
        .rd_level (stored_level),
        .levels   (pin_levels)
    );

    irq_line_counters #(
        .NUM_DEV   (NUM_DEV),
        .NUM_LINES (NUM_LINES)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (apply_step),
        .step_up   (cap_level),
        .step_line (cap_line),
        .cnt_flat  (line_cnt),
        .line_out  (line_out)
    );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV   = 8,
    parameter int NUM_LINES = 4,
    localparam int SRC_N = NUM_DEV * PINS_PER_DEV,
    localparam int CNT_W = $clog2(SRC_N + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [NUM_LINES-1:0]       line_out,
    input logic [SRC_N-1:0]           levels,
    input logic [NUM_LINES*CNT_W-1:0] cnt_flat
);

    int cnt_sum;
    always_comb begin
        cnt_sum = 0;
        for (int l = 0; l < NUM_LINES; l++) begin
            cnt_sum += int'(cnt_flat[l*CNT_W +: CNT_W]);
        end
    end

    // R2: one busy cycle after every acceptance
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    p_ready_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready);

    // R3: single-step changes on the line outputs
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(line_out ^ $past(line_out)) <= 1);

    // R4: counters agree with the pin store
    p_count_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_sum == $countones(levels));

    // R9: no line change on the edge that ends a waiting cycle
    p_hold_while_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> $stable(line_out));

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
            // R8: bounded counters
            p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                int'(cnt_flat[l*CNT_W +: CNT_W]) <= SRC_N);
            p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_flat[l*CNT_W +: CNT_W] == '0 |=> int'(cnt_flat[l*CNT_W +: CNT_W]) <= 1);
        end
    endgenerate

endmodule

bind irq_line_aggregator irq_agg_checker #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .line_out  (line_out),
    .levels    (pin_levels),
    .cnt_flat  (line_cnt)
);

// File: tb/test_irq_line_aggregator.sv
module test_irq_line_aggregator;

    localparam int NDEV  = 8;
    localparam int NLINE = 4;
    localparam int BSLOT = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_dev = '0;
    logic [1:0]       req_pin = '0;
    logic             req_level = 1'b0;
    logic             ready_d, ready_b;
    logic [NLINE-1:0] line_d, line_b;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  model [NDEV][4];

    always #10 clk = ~clk;

    irq_line_aggregator #(.NUM_DEV(NDEV), .NUM_LINES(NLINE)) i_irq_line_aggregator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_d),
        .req_dev(req_dev), .req_pin(req_pin), .req_level(req_level), .line_out(line_d)
    );

    irq_line_aggregator #(.NUM_DEV(NDEV), .NUM_LINES(NLINE), .HAS_BRIDGE(1'b1),
                          .BRIDGE_SLOT(BSLOT)) i_irq_line_aggregator_br (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_b),
        .req_dev(req_dev), .req_pin(req_pin), .req_level(req_level), .line_out(line_b)
    );

    function automatic int map_direct(int d, int p);
        return (d + p) % NLINE;
    endfunction

    function automatic int map_bridged(int d, int p);
        return (BSLOT + ((d + p) % 4)) % NLINE;
    endfunction

    function automatic logic [NLINE-1:0] expect_lines(bit bridged);
        logic [NLINE-1:0] v = '0;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++)
                if (model[d][p]) v[bridged ? map_bridged(d, p) : map_direct(d, p)] = 1'b1;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_model(string req);
        check({req, " direct"}, 32'(line_d), 32'(expect_lines(1'b0)));
        check("R10 bridged", 32'(line_b), 32'(expect_lines(1'b1)));
    endtask

    // one report; R2 and R9 are checked on every report
    task automatic send(int d, int p, bit lvl);
        logic [NLINE-1:0] before_d;
        @(negedge clk);
        check("R2 ready before", 32'(ready_d), 32'd1);
        before_d  = line_d;
        req_valid = 1'b1;
        req_dev   = 3'(d);
        req_pin   = 2'(p);
        req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy", 32'(ready_d), 32'd0);
        check("R9 hold", 32'(line_d), 32'(before_d));
        model[d][p] = lvl;
        @(negedge clk);
        check("R2 ready again", 32'(ready_d), 32'd1);
    endtask

    task automatic t_reset;
        check("R1 lines", 32'(line_d), 32'd0);
        check("R1 lines bridged", 32'(line_b), 32'd0);
        check("R1 ready", 32'(ready_d), 32'd1);
    endtask

    task automatic t_mapping;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++) begin
                send(d, p, 1'b1);
                check("R6 one-hot", 32'(line_d), 32'(1 << map_direct(d, p)));
                check("R10 one-hot", 32'(line_b), 32'(1 << map_bridged(d, p)));
                send(d, p, 1'b0);
                check_model("R3 lower");
            end
    endtask

    task automatic t_shared;
        send(0, 0, 1'b1);
        send(1, 3, 1'b1);
        send(0, 0, 1'b0);
        check("R5 still high", 32'(line_d[0]), 32'd1);
        send(1, 3, 1'b0);
        check("R5 last drop", 32'(line_d[0]), 32'd0);
        check_model("R5");
    endtask

    task automatic t_repeat;
        send(2, 1, 1'b1);
        send(2, 1, 1'b1);
        send(2, 1, 1'b0);
        check("R4 no double count", 32'(line_d), 32'd0);
        check_model("R4");
    endtask

    task automatic t_lower_idle;
        send(3, 0, 1'b1);
        send(0, 3, 1'b0);
        check("R7 other source kept", 32'(line_d), 32'b1000);
        send(3, 0, 1'b0);
        check("R7 drop", 32'(line_d), 32'd0);
        check_model("R7");
    endtask

    task automatic t_full;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++) begin
                send(d, p, 1'b1);
                if (p == 2) send(d, p, 1'b1);
            end
        check("R8 all high", 32'(line_d), 32'hF);
        check_model("R8 full");
        for (int d = NDEV - 1; d >= 0; d--)
            for (int p = 0; p < 4; p++) begin
                send(d, p, 1'b0);
                if (p == 1) send(d, p, 1'b0);
                check_model("R8 drain");
            end
        check("R8 all low", 32'(line_d), 32'd0);
    endtask

    initial begin
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++) model[d][p] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_shared();
        t_repeat();
        t_lower_idle();
        t_full();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule